// File: doc/BRIEF.md
# Pseudo-Random Priority Arbiter

This block shares one resource among N requesters. Every clock cycle the search order starts at a new requester chosen by a free-running maximal-length linear feedback shift register. The arbiter keeps no record of earlier requests or grants. Over a long run each requester is put first about equally often, with no fixed winner and no rotation that can be predicted from the grant pattern.

The low log2(N) bits of the register state form a priority index. That index is decoded to a one-hot pointer. A circular fixed-priority selector then picks the first active request at or after the pointer. The chosen grant is registered. The register state is also brought out on a port, so a consumer or a bench can see which pointer is used in each cycle.

The selector can be built in one of two forms, picked by a parameter: a mask-and-isolate form, or an unrolled circular scan. The port behaviour of the two is identical.

Top module: `rpa_arbiter`

## Requirements
- R1: While `rst` is high at a rising edge, the next outputs are `gnt` = 0 and `lfsr_state` = SEED (default 16'hACE1 for W=16), whatever `req` is.
- R2: Each rising edge out of reset advances the state as a left shift: next = {s[W-2:0], fb}. `fb` is the XOR of the tap bits. For W=16 the taps are bits 15, 14, 12 and 3; for W=8 they are bits 7, 5, 4 and 3.
- R3: After reset the state never reads zero. It first returns to SEED after exactly 2^W-1 steps.
- R4: The value on `lfsr_state` differs between any two consecutive cycles out of reset.
- R5: The priority index is p = s[log2(N)-1:0] of the state seen before the edge. With all requests active, the grant is exactly bit p.
- R6: The granted index is the lowest active request index at or above p. If no request is active at or above p, it is the lowest active index overall.
- R7: The grant is registered. The value on `gnt` after an edge depends only on `req` and `lfsr_state` as they were just before that edge.
- R8: At most one bit of `gnt` is high.
- R9: A `gnt` bit is high only if the matching `req` bit was high in the cycle before.
- R10: If any request was high in the cycle before, exactly one grant is issued. If none was high, `gnt` is zero.
- R11: N is a parameter (a power of two from 2 to 32, covering 4, 8, 16 and 32). W is a parameter from a supported set (8, 12, 16, 20, 24, 32) with W >= log2(N). The same rules hold for N=4 with W=8 and the scan-form selector.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| req | input | N | Request vector, one bit per requester |
| gnt | output | N | Registered one-hot grant vector |
| lfsr_state | output | W | Current shift register state |

## Verification
A corrupted shift register state shows on `lfsr_state` at the very next edge: it breaks the one-step successor relation, and a zero or stuck value shows as a repeated word. A wrong pointer decode or a wrong selector shows in `gnt` one cycle after the request pattern that exposes it. Such a pattern is an all-ones request, or one where the only active requests lie below the pointer. A fault in period length appears only as an early or late return to the seed, which takes a full 2^W-1 cycle sweep to observe.

// File: rtl/rpa_pkg.sv
package rpa_pkg;

   // Feedback masks for maximal-length shift registers (bit i = tap at state[i]).
   function automatic logic [31:0] tap_mask(input int w);
      logic [31:0] m;
      case (w)
         8:       m = 32'h0000_00B8;
         12:      m = 32'h0000_0829;
         16:      m = 32'h0000_D008;
         20:      m = 32'h0009_0000;
         24:      m = 32'h00E1_0000;
         32:      m = 32'h8020_0003;
         default: m = 32'h0000_0000;
      endcase
      return m;
   endfunction

   function automatic bit is_pow2(input int v);
      return (v > 0) && ((v & (v - 1)) == 0);
   endfunction

endpackage

// File: rtl/rpa_lfsr.sv
module rpa_lfsr #(
   parameter int          W    = 16,
   parameter logic [31:0] SEED = 32'h0000_ACE1,
   parameter logic [31:0] MASK = 32'h0000_D008
) (
   input  logic         clk,
   input  logic         rst,
   output logic [W-1:0] state
);
   localparam logic [W-1:0] TAPS  = MASK[W-1:0];
   localparam logic [W-1:0] START = SEED[W-1:0];

   logic [W-1:0] q;
   logic         fb;

   always_comb fb = ^(q & TAPS);

   always_ff @(posedge clk) begin
      if (rst) q <= START;
      else     q <= {q[W-2:0], fb};
   end

   assign state = q;
endmodule

// File: rtl/rpa_ptr_decode.sv
module rpa_ptr_decode #(
   parameter int N  = 8,
   localparam int PW = (N > 1) ? $clog2(N) : 1
) (
   input  logic [PW-1:0] idx,
   output logic [N-1:0]  ptr_oh
);
   for (genvar i = 0; i < N; i++) begin : g_dec
      assign ptr_oh[i] = (idx == PW'(i));
   end
endmodule

// File: rtl/rpa_circ_select.sv
module rpa_circ_select #(
   parameter int N    = 8,
   parameter int IMPL = 0,
   localparam int PW  = (N > 1) ? $clog2(N) : 1
) (
   input  logic [N-1:0] req,
   input  logic [N-1:0] ptr_oh,
   output logic [N-1:0] gnt
);
   if (IMPL == 0) begin : g_mask
      logic [N-1:0] upper;
      logic [N-1:0] pick;
      always_comb begin
         upper = req & ~(ptr_oh - N'(1));
         pick  = (|upper) ? upper : req;
         gnt   = pick & (~pick + N'(1));
      end
   end else if (IMPL == 1) begin : g_scan
      logic [PW-1:0] pidx;
      logic [PW-1:0] j;
      logic          hit;
      always_comb begin
         pidx = '0;
         for (int k = 0; k < N; k++) begin
            if (ptr_oh[k]) pidx = PW'(k);
         end
         gnt = '0;
         hit = 1'b0;
         j   = '0;
         for (int off = 0; off < N; off++) begin
            j = pidx + PW'(off);
            if (!hit && req[j]) begin
               gnt[j] = 1'b1;
               hit    = 1'b1;
            end
         end
      end
   end else begin : g_bad
      $error("rpa_circ_select: IMPL must be 0 or 1");
   end
endmodule

// File: rtl/rpa_arbiter.sv
module rpa_arbiter #(
   parameter int          N        = 8,
   parameter int          W        = 16,
   parameter logic [31:0] SEED     = 32'h0000_ACE1,
   parameter int          SEL_IMPL = 0
) (
   input  logic         clk,
   input  logic         rst,
   input  logic [N-1:0] req,
   output logic [N-1:0] gnt,
   output logic [W-1:0] lfsr_state
);
   import rpa_pkg::*;

   localparam int          PW   = (N > 1) ? $clog2(N) : 1;
   localparam logic [31:0] MASK = tap_mask(W);

   if (N < 2 || N > 32 || !is_pow2(N)) begin : g_chk_n
      $error("rpa_arbiter: N must be a power of two in 2..32");
   end
   if (MASK == 32'h0) begin : g_chk_w
      $error("rpa_arbiter: W has no tap table entry");
   end
   if (W < PW) begin : g_chk_wpw
      $error("rpa_arbiter: W narrower than pointer index");
   end
   if (SEED[W-1:0] == '0) begin : g_chk_seed
      $error("rpa_arbiter: SEED must be nonzero");
   end

   logic [W-1:0] st;
   logic [N-1:0] ptr_oh;
   logic [N-1:0] sel;
   logic [N-1:0] gnt_q;

   rpa_lfsr #(.W(W), .SEED(SEED), .MASK(MASK)) u_lfsr (
      .clk   (clk),
      .rst   (rst),
      .state (st)
   );

   rpa_ptr_decode #(.N(N)) u_dec (
      .idx    (st[PW-1:0]),
      .ptr_oh (ptr_oh)
   );

   rpa_circ_select #(.N(N), .IMPL(SEL_IMPL)) u_sel (
      .req    (req),
      .ptr_oh (ptr_oh),
      .gnt    (sel)
   );

   always_ff @(posedge clk) begin
      if (rst) gnt_q <= '0;
      else     gnt_q <= sel;
   end

   assign gnt        = gnt_q;
   assign lfsr_state = st;
endmodule

// File: rtl/rpa_arbiter_chk.sv
module rpa_arbiter_chk #(
   parameter int N = 8,
   parameter int W = 16
) (
   input logic         clk,
   input logic         rst,
   input logic [N-1:0] req,
   input logic [N-1:0] gnt,
   input logic [W-1:0] lfsr_state
);
   logic live;
   always_ff @(posedge clk) begin
      if (rst) live <= 1'b0;
      else     live <= 1'b1;
   end

   // R8
   grant_onehot_chk: assert property (@(posedge clk) disable iff (rst)
      live |-> $onehot0(gnt));

   // R9
   grant_has_req_chk: assert property (@(posedge clk) disable iff (rst)
      live |-> ((gnt & ~$past(req)) == '0));

   // R10
   grant_when_busy_chk: assert property (@(posedge clk) disable iff (rst)
      (live && (|$past(req))) |-> (|gnt));

   // R10
   idle_no_grant_chk: assert property (@(posedge clk) disable iff (rst)
      (live && !(|$past(req))) |-> (gnt == '0));

   // R3
   state_nonzero_chk: assert property (@(posedge clk) disable iff (rst)
      live |-> (lfsr_state != '0));

   // R4
   state_moves_chk: assert property (@(posedge clk) disable iff (rst)
      live |-> (lfsr_state != $past(lfsr_state)));
endmodule

bind rpa_arbiter rpa_arbiter_chk #(.N(N), .W(W)) u_chk (
   .clk        (clk),
   .rst        (rst),
   .req        (req),
   .gnt        (gnt),
   .lfsr_state (lfsr_state)
);

// File: tb/rpa_arbiter_test.sv
module rpa_arbiter_test;
   localparam logic [31:0] SEED8 = 32'h0000_ACE1;
   localparam logic [31:0] SEED4 = 32'h0000_005A;
   localparam logic [31:0] TAP16 = 32'h0000_D008; // bits 15,14,12,3
   localparam logic [31:0] TAP8  = 32'h0000_00B8; // bits 7,5,4,3

   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic [7:0]  req8 = '0;
   logic [7:0]  gnt8;
   logic [15:0] lfsr8;
   logic [3:0]  req4 = '0;
   logic [3:0]  gnt4;
   logic [7:0]  lfsr4;

   int checks = 0;
   int errors = 0;
   bit done   = 1'b0;

   always #4 clk = ~clk;

   rpa_arbiter #(.N(8), .W(16), .SEED(SEED8), .SEL_IMPL(0)) uut (
      .clk(clk), .rst(rst), .req(req8), .gnt(gnt8), .lfsr_state(lfsr8));

   rpa_arbiter #(.N(4), .W(8), .SEED(SEED4), .SEL_IMPL(1)) uut4 (
      .clk(clk), .rst(rst), .req(req4), .gnt(gnt4), .lfsr_state(lfsr4));

   function automatic logic [31:0] nxt(logic [31:0] s, logic [31:0] taps, int w);
      logic [31:0] m;
      logic        fb;
      m  = (w == 32) ? 32'hFFFF_FFFF : ((32'd1 << w) - 32'd1);
      fb = ^(s & taps);
      return ((s << 1) | {31'd0, fb}) & m;
   endfunction

   function automatic logic [31:0] pick(logic [31:0] r, int p, int n);
      for (int off = 0; off < n; off++) begin
         int j;
         j = (p + off) % n;
         if (r[j]) return 32'd1 << j;
      end
      return 32'd0;
   endfunction

   task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   // Called just after a falling edge: drive, sample, then check after the rising edge.
   task automatic apply(input logic [7:0] r8, input logic [3:0] r4);
      logic [15:0] s8;
      logic [7:0]  s4;
      logic [31:0] e8, e4;
      req8 = r8;
      req4 = r4;
      s8 = lfsr8;
      s4 = lfsr4;
      e8 = pick({24'd0, r8}, int'(s8[2:0]), 8);
      e4 = pick({28'd0, r4}, int'(s4[1:0]), 4);
      @(posedge clk);
      #1;
      // R6 R7: circular pick from pre-edge pointer, registered
      chk(gnt8 == e8[7:0], "R6/R7 grant", {24'd0, gnt8}, e8);
      // R2
      chk(lfsr8 == nxt({16'd0, s8}, TAP16, 16)[15:0], "R2 step", {16'd0, lfsr8}, nxt({16'd0, s8}, TAP16, 16));
      // R4
      chk(lfsr8 != s8, "R4 differs", {16'd0, lfsr8}, {16'd0, s8});
      // R8 R9 R10
      chk($countones(gnt8) == ((r8 != 0) ? 1 : 0), "R8/R10 count", {24'd0, gnt8}, {24'd0, r8});
      chk((gnt8 & ~r8) == 0, "R9 no request", {24'd0, gnt8}, {24'd0, r8});
      // R11: small configuration with scan selector
      chk(gnt4 == e4[3:0], "R11 grant n4", {28'd0, gnt4}, e4);
      chk(lfsr4 == nxt({24'd0, s4}, TAP8, 8)[7:0], "R11 step w8", {24'd0, lfsr4}, nxt({24'd0, s4}, TAP8, 8));
   endtask

   task automatic reset_check(input string tag);
      @(negedge clk);
      rst  = 1'b1;
      req8 = 8'hFF;
      req4 = 4'hF;
      @(posedge clk);
      #1;
      // R1
      chk(gnt8 == 0,              {tag, " R1 gnt"},  {24'd0, gnt8}, 32'd0);
      chk(lfsr8 == SEED8[15:0],   {tag, " R1 seed"}, {16'd0, lfsr8}, SEED8);
      chk(gnt4 == 0 && lfsr4 == SEED4[7:0], {tag, " R1/R11 small"}, {20'd0, gnt4, lfsr4}, {24'd0, SEED4[7:0]});
      @(negedge clk);
      rst  = 1'b0;
      req8 = '0;
      req4 = '0;
   endtask

   initial begin : watchdog
      repeat (200000) @(posedge clk);
      if (!done) begin
         errors++;
         $display("FAIL watchdog expired actual=%0d expected=%0d", 200000, 0);
         $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   initial begin : main
      int unsigned sv;
      int first8, first4;
      bit zero_seen;
      sv = $urandom(32'd2024);

      repeat (3) @(posedge clk);
      reset_check("initial");

      // R3: period sweep with idle requests
      first8 = 0; first4 = 0; zero_seen = 1'b0;
      for (int i = 1; i <= 65600 && first8 == 0; i++) begin
         @(posedge clk);
         #1;
         if (lfsr8 == 0 || lfsr4 == 0) zero_seen = 1'b1;
         if (first8 == 0 && lfsr8 == SEED8[15:0]) first8 = i;
         if (first4 == 0 && lfsr4 == SEED4[7:0])  first4 = i;
      end
      chk(first8 == 65535, "R3 period w16", first8, 65535);
      chk(first4 == 255,   "R3/R11 period w8", first4, 255);
      chk(!zero_seen,      "R3 never zero", {31'd0, zero_seen}, 32'd0);

      // R5: all requests active, each pointer value
      for (int p = 0; p < 8; p++) begin
         @(negedge clk);
         while (lfsr8[2:0] != p[2:0]) @(negedge clk);
         apply(8'hFF, 4'hF);
         chk(gnt8 == (8'd1 << p), "R5 all-ones", {24'd0, gnt8}, 32'd1 << p);
      end

      // R6: only requests below the pointer, must wrap to lowest
      for (int p = 1; p < 8; p++) begin
         @(negedge clk);
         while (lfsr8[2:0] != p[2:0]) @(negedge clk);
         apply(8'((16'd1 << p) - 1), 4'h1);
         chk(gnt8 == 8'h01, "R6 wrap", {24'd0, gnt8}, 32'h1);
      end

      // R10: idle and single-request cases
      @(negedge clk); apply(8'h00, 4'h0);
      chk(gnt8 == 0 && gnt4 == 0, "R10 idle", {24'd0, gnt8}, 32'd0);
      for (int b = 0; b < 8; b++) begin
         @(negedge clk); apply(8'd1 << b, 4'd1 << (b % 4));
         chk(gnt8 == (8'd1 << b), "R9 single", {24'd0, gnt8}, 32'd1 << b);
      end

      // Constrained random traffic: sparse, dense, uniform
      for (int k = 0; k < 2000; k++) begin
         logic [7:0] r8;
         logic [3:0] r4;
         case ($urandom_range(0, 2))
            0: r8 = 8'd1 << $urandom_range(0, 7);
            1: r8 = 8'($urandom) | 8'($urandom);
            default: r8 = 8'($urandom);
         endcase
         r4 = 4'($urandom);
         @(negedge clk);
         apply(r8, r4);
      end

      // R1: reset in the middle of traffic
      reset_check("midrun");
      @(negedge clk); apply(8'hA5, 4'h6);

      done = 1'b1;
      $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule